// File: doc/BRIEF.md
# PWM Motor Gate Controller with Latching Torque Limit

This block is the digital core of a motor switch controller. A triangle counter sweeps up and down between one third and two thirds of its code range. A speed command code is compared against the triangle to form a pulse-width modulated gate signal. A lower command code gives a wider pulse and so a faster motor. The gate output drives the control input of an external power switch.

Over-current is only judged while a sense window is open. The window is a second comparison of the triangle against the command, with a small margin added. It has the same period as the gate pulse, is a few percent shorter, and is centred inside it. While the window is open and 80% of the sampled drain code is above the torque reference code, a delay accumulator counts up. When the count would reach a quarter of the accumulator's range, a fault latch sets and clears the accumulator. The latch then holds the gate low. Only the synchronous reset clears the latch.

All sizes are parameters. The triangle step rate comes from a clock divider whose default gives a 200 µs sweep period from a 100 MHz clock.

Top module: `motor_torque_pwm`

## Requirements
- R1: After reset the triangle value starts at LOW = floor(2^TRI_W/3) and steps by exactly one per divider tick. It rises to HIGH = floor(2*2^TRI_W/3), then falls back to LOW, and repeats. The slope is the same in both directions.
- R2: One sweep lasts 2*(HIGH-LOW)*TICK_DIV clock cycles, so gate_o has exactly one rising edge per sweep. The default TICK_DIV gives a 200 µs period at CLK_KHZ = 100000.
- R3: gate_o is registered and is high in the cycle after the triangle is strictly above speed_cmd_i. Per sweep with TICK_DIV = 1, the number of high cycles is:
  - 2*(HIGH-cmd)-1 for LOW <= cmd < HIGH;
  - the full sweep for cmd < LOW;
  - zero for cmd >= HIGH.
- R4: The sense window is open while the triangle is strictly above speed_cmd_i + MARGIN, where MARGIN = floor((HIGH-LOW)/20). The window opens MARGIN steps after the gate pulse starts and closes MARGIN steps before it ends. The accumulator never advances in a cycle where gate_o is low.
- R5: Over-current is the window being open and 4*drain_sns_i > 5*torque_ref_i. Equality does not count.
- R6: delay_acc_o rises by one in each over-current cycle and holds its value in every other cycle while the latch is clear.
- R7: In an over-current cycle with delay_acc_o = 2^ACC_W/4 - 1, fault_o sets and delay_acc_o returns to 0 at the same edge. While fault_o is set, delay_acc_o stays at 0.
- R8: gate_o is low in every cycle in which fault_o is high, including the cycle in which the latch sets.
- R9: Once set, fault_o stays high whatever the inputs do. Only rst clears it.
- R10: While rst is high, gate_o, fault_o and delay_acc_o are 0. After rst the gate follows the command again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| speed_cmd_i | input | TRI_W | Speed command code; lower code gives wider gate pulse |
| drain_sns_i | input | SNS_W | Sampled drain-current code |
| torque_ref_i | input | SNS_W | Torque reference code |
| gate_o | output | 1 | Registered gate drive |
| fault_o | output | 1 | Sticky torque-limit latch |
| delay_acc_o | output | ACC_W | Delay accumulator value |

## Verification
Gate duty is measured over whole sweeps for five command codes:
- a mid-range code and a lower one, which separate the duty direction and check the pulse-width formula;
- a code below LOW, which tells an always-on gate from an off-by-one;
- the LOW code itself, which is one cycle short of full;
- a code at or above HIGH, where the gate must stay off.

With over-current held, the offset from the gate edge to the first accumulator step and the step count per sweep show that the window is narrower than the gate and centred in it.

The drain and torque codes are placed on both sides of the 4:5 boundary, equality included, to show a strict compare.

A long over-current run checks three things:
- the accumulator value just before the latch sets;
- the cleared accumulator and low gate at the edge where it sets;
- that the latch holds after the over-current is removed, until reset.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

  typedef enum logic {
    SWEEP_UP   = 1'b0,
    SWEEP_DOWN = 1'b1
  } sweep_dir_e;

  // Lower turning point of the triangle for a given counter width.
  function automatic int tri_low(input int w);
    return (1 << w) / 3;
  endfunction

  // Upper turning point of the triangle for a given counter width.
  function automatic int tri_high(input int w);
    return (2 * (1 << w)) / 3;
  endfunction

  // Clock cycles per triangle step for a wanted sweep period.
  function automatic int step_div(input int w, input int clk_khz, input int period_us);
    int span;
    int d;
    span = tri_high(w) - tri_low(w);
    d = (clk_khz / 1000) * period_us / (2 * span);
    return (d < 1) ? 1 : d;
  endfunction

endpackage

// File: rtl/tri_sweep.sv
module tri_sweep #(
  parameter int TRI_W    = 9,
  parameter int TICK_DIV = 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [TRI_W-1:0] tri_o
);
  import mtp_pkg::*;

  localparam int LOW  = tri_low(TRI_W);
  localparam int HIGH = tri_high(TRI_W);

  logic             step;
  logic [TRI_W-1:0] tri_q;
  sweep_dir_e       dir_q;

  generate
    if (TICK_DIV <= 1) begin : g_every_cycle
      assign step = 1'b1;
    end else begin : g_divided
      localparam int DW = $clog2(TICK_DIV);
      logic [DW-1:0] div_q;
      assign step = (div_q == DW'(TICK_DIV - 1));
      always_ff @(posedge clk) begin
        if (rst || step) div_q <= '0;
        else             div_q <= div_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      tri_q <= TRI_W'(LOW);
      dir_q <= SWEEP_UP;
    end else if (step) begin
      if (dir_q == SWEEP_UP) begin
        if (tri_q == TRI_W'(HIGH)) begin
          dir_q <= SWEEP_DOWN;
          tri_q <= tri_q - 1'b1;
        end else begin
          tri_q <= tri_q + 1'b1;
        end
      end else begin
        if (tri_q == TRI_W'(LOW)) begin
          dir_q <= SWEEP_UP;
          tri_q <= tri_q + 1'b1;
        end else begin
          tri_q <= tri_q - 1'b1;
        end
      end
    end
  end

  assign tri_o = tri_q;

endmodule

// File: rtl/pwm_window_cmp.sv
module pwm_window_cmp #(
  parameter int TRI_W = 9
) (
  input  logic [TRI_W-1:0] tri_i,
  input  logic [TRI_W-1:0] cmd_i,
  output logic             pwm_o,
  output logic             win_o
);
  import mtp_pkg::*;

  localparam int SPAN   = tri_high(TRI_W) - tri_low(TRI_W);
  localparam int MARGIN = SPAN / 20;

  logic [TRI_W:0] win_thr;

  // One extra bit so that a high command plus margin cannot wrap.
  assign win_thr = {1'b0, cmd_i} + (TRI_W+1)'(MARGIN);
  assign pwm_o   = (tri_i > cmd_i);
  assign win_o   = ({1'b0, tri_i} > win_thr);

endmodule

// File: rtl/torque_guard.sv
module torque_guard #(
  parameter int SNS_W = 8,
  parameter int ACC_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_i,
  input  logic [SNS_W-1:0] drain_i,
  input  logic [SNS_W-1:0] torque_i,
  output logic             oc_o,
  output logic             trip_o,
  output logic             fault_o,
  output logic [ACC_W-1:0] acc_o
);
  localparam int SW     = SNS_W + 3;
  localparam int THRESH = 1 << (ACC_W - 2);

  logic [SW-1:0]    drain_x4;
  logic [SW-1:0]    torque_x5;
  logic [ACC_W-1:0] acc_q;
  logic             fault_q;

  assign drain_x4  = SW'(drain_i) << 2;
  assign torque_x5 = (SW'(torque_i) << 2) + SW'(torque_i);
  assign oc_o      = win_i && (drain_x4 > torque_x5);
  assign trip_o    = oc_o && !fault_q && (acc_q == ACC_W'(THRESH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      fault_q <= 1'b0;
    end else if (fault_q) begin
      acc_q   <= '0;
    end else if (trip_o) begin
      acc_q   <= '0;
      fault_q <= 1'b1;
    end else if (oc_o) begin
      acc_q   <= acc_q + 1'b1;
    end
  end

  assign fault_o = fault_q;
  assign acc_o   = acc_q;

endmodule

// File: rtl/motor_torque_pwm.sv
module motor_torque_pwm #(
  parameter int TRI_W     = 9,
  parameter int SNS_W     = 8,
  parameter int ACC_W     = 12,
  parameter int CLK_KHZ   = 100000,
  parameter int PERIOD_US = 200,
  parameter int TICK_DIV  = mtp_pkg::step_div(TRI_W, CLK_KHZ, PERIOD_US)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TRI_W-1:0] speed_cmd_i,
  input  logic [SNS_W-1:0] drain_sns_i,
  input  logic [SNS_W-1:0] torque_ref_i,
  output logic             gate_o,
  output logic             fault_o,
  output logic [ACC_W-1:0] delay_acc_o
);

  logic [TRI_W-1:0] tri_val;
  logic             pwm_raw;
  logic             sense_win;
  logic             over_cur;
  logic             trip;
  logic             gate_q;

  tri_sweep #(.TRI_W(TRI_W), .TICK_DIV(TICK_DIV)) u_sweep (
    .clk   (clk),
    .rst   (rst),
    .tri_o (tri_val)
  );

  pwm_window_cmp #(.TRI_W(TRI_W)) u_cmp (
    .tri_i (tri_val),
    .cmd_i (speed_cmd_i),
    .pwm_o (pwm_raw),
    .win_o (sense_win)
  );

  torque_guard #(.SNS_W(SNS_W), .ACC_W(ACC_W)) u_guard (
    .clk      (clk),
    .rst      (rst),
    .win_i    (sense_win),
    .drain_i  (drain_sns_i),
    .torque_i (torque_ref_i),
    .oc_o     (over_cur),
    .trip_o   (trip),
    .fault_o  (fault_o),
    .acc_o    (delay_acc_o)
  );

  // The trip term cuts the gate on the same edge the latch sets.
  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= pwm_raw && !fault_o && !trip;
  end

  assign gate_o = gate_q;

endmodule

// File: rtl/motor_torque_pwm_chk.sv
module motor_torque_pwm_chk #(
  parameter int TRI_W = 9,
  parameter int ACC_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [TRI_W-1:0] tri_val,
  input logic             pwm_raw,
  input logic             sense_win,
  input logic             over_cur,
  input logic             gate_o,
  input logic             fault_o,
  input logic [ACC_W-1:0] delay_acc_o
);
  localparam int LOW    = mtp_pkg::tri_low(TRI_W);
  localparam int HIGH   = mtp_pkg::tri_high(TRI_W);
  localparam int THRESH = 1 << (ACC_W - 2);

  p_tri_range_r1: assert property (@(posedge clk) disable iff (rst)
    (tri_val >= TRI_W'(LOW)) && (tri_val <= TRI_W'(HIGH)));

  p_tri_unit_step_r1: assert property (@(posedge clk) disable iff (rst)
    (tri_val != $past(tri_val)) |->
      ((tri_val == TRI_W'($past(tri_val) + 1'b1)) || (tri_val == TRI_W'($past(tri_val) - 1'b1))));

  p_win_inside_pwm_r4: assert property (@(posedge clk) disable iff (rst)
    sense_win |-> pwm_raw);

  p_acc_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !over_cur |=> $stable(delay_acc_o));

  p_acc_below_quarter_r7: assert property (@(posedge clk) disable iff (rst)
    delay_acc_o < ACC_W'(THRESH));

  p_acc_zero_on_trip_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_o) |-> (delay_acc_o == '0));

  p_gate_off_in_fault_r8: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> !gate_o);

  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    fault_o |=> fault_o);

endmodule

bind motor_torque_pwm motor_torque_pwm_chk #(.TRI_W(TRI_W), .ACC_W(ACC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tri_val     (tri_val),
  .pwm_raw     (pwm_raw),
  .sense_win   (sense_win),
  .over_cur    (over_cur),
  .gate_o      (gate_o),
  .fault_o     (fault_o),
  .delay_acc_o (delay_acc_o)
);

// File: tb/motor_torque_pwm_bench.sv
module motor_torque_pwm_bench;

  localparam int TRI_W  = 9;
  localparam int SNS_W  = 8;
  localparam int ACC_W  = 9;
  localparam int LOW    = 512 / 3;            // 170
  localparam int HIGH   = 1024 / 3;           // 341
  localparam int SWEEP  = 2 * (HIGH - LOW);   // 342 cycles
  localparam int MARGIN = (HIGH - LOW) / 20;  // 8
  localparam int QUART  = 512 / 4;            // 128

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [TRI_W-1:0] speed_cmd = '0;
  logic [SNS_W-1:0] drain = '0;
  logic [SNS_W-1:0] torque = '0;
  logic             gate_o;
  logic             fault_o;
  logic [ACC_W-1:0] delay_acc_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  typedef struct {
    string tag;
    int    val;
  } item_t;

  item_t exp_q[$];
  int    act_q[$];

  always #5 clk = ~clk;

  motor_torque_pwm #(
    .TRI_W(TRI_W), .SNS_W(SNS_W), .ACC_W(ACC_W), .TICK_DIV(1)
  ) u_motor_torque_pwm (
    .clk          (clk),
    .rst          (rst),
    .speed_cmd_i  (speed_cmd),
    .drain_sns_i  (drain),
    .torque_ref_i (torque),
    .gate_o       (gate_o),
    .fault_o      (fault_o),
    .delay_acc_o  (delay_acc_o)
  );

  // Driver side: expected items enter the scoreboard here.
  task automatic expect_val(input string tag, input int v);
    item_t it;
    it.tag = tag;
    it.val = v;
    exp_q.push_back(it);
  endtask

  task automatic report_val(input int v);
    act_q.push_back(v);
  endtask

  // Monitor side: pair expected and actual items in order.
  always @(negedge clk) begin
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      item_t e;
      int    a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      n_checks++;
      if (a != e.val) begin
        n_errors++;
        $display("FAIL %s: actual %0d expected %0d", e.tag, a, e.val);
      end
    end
  end

  function automatic int duty_of(input int cmd);
    if (cmd < LOW)   return SWEEP;
    if (cmd >= HIGH) return 0;
    return 2 * (HIGH - cmd) - 1;
  endfunction

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic apply_reset;
    rst = 1'b1;
    cyc(3);
    expect_val("R10 reset gate", 0);  report_val(int'(gate_o));
    expect_val("R10 reset fault", 0); report_val(int'(fault_o));
    expect_val("R10 reset acc", 0);   report_val(int'(delay_acc_o));
    rst = 1'b0;
  endtask

  task automatic check_duty(input string tag, input int cmd);
    int hi;
    hi = 0;
    speed_cmd = TRI_W'(cmd);
    cyc(2);
    for (int i = 0; i < SWEEP; i++) begin
      @(negedge clk);
      if (gate_o) hi++;
    end
    expect_val(tag, duty_of(cmd));
    report_val(hi);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin : stim
    int rises;
    int first_step;
    int bad;
    int prev_acc;
    int waited;
    logic prev_gate;

    torque = 8'd255;
    drain  = 8'd0;
    speed_cmd = TRI_W'(300);
    apply_reset();

    // R3: duty formula across command codes, lower code gives more
    check_duty("R3 duty cmd=300", 300);
    check_duty("R3 duty cmd=250", 250);
    check_duty("R3 duty cmd=0 full on", 0);
    check_duty("R3 duty cmd=LOW", LOW);
    check_duty("R3 duty cmd=400 off", 400);

    // R1 R2: one gate rise per sweep
    speed_cmd = TRI_W'(300);
    cyc(2);
    rises = 0;
    prev_gate = gate_o;
    for (int i = 0; i < 3 * SWEEP; i++) begin
      @(negedge clk);
      if (gate_o && !prev_gate) rises++;
      prev_gate = gate_o;
    end
    expect_val("R2 rises in three sweeps", 3);
    report_val(rises);
    expect_val("R6 no oc acc stays 0", 0);
    report_val(int'(delay_acc_o));

    // R4 R5 R6: window position and width under constant over-current
    drain = 8'd51;
    torque = 8'd40;
    speed_cmd = TRI_W'(300);
    apply_reset();
    waited = 0;
    while (!gate_o && waited < 2 * SWEEP) begin
      @(negedge clk);
      waited++;
    end
    first_step = -1;
    bad = 0;
    prev_acc = int'(delay_acc_o);
    for (int i = 1; i <= SWEEP; i++) begin
      @(negedge clk);
      if (int'(delay_acc_o) != prev_acc) begin
        if (first_step < 0) first_step = i;
        if (!gate_o) bad++;
      end
      prev_acc = int'(delay_acc_o);
    end
    expect_val("R4 window lag after gate rise", MARGIN);
    report_val(first_step);
    expect_val("R4 steps outside gate", 0);
    report_val(bad);
    expect_val("R6 acc after one sweep", duty_of(300 + MARGIN));
    report_val(int'(delay_acc_o));

    // R6: hold without over-current
    drain = 8'd0;
    cyc(SWEEP);
    expect_val("R6 acc holds", duty_of(300 + MARGIN));
    report_val(int'(delay_acc_o));

    // R5: 4*50 == 5*40 is not over-current
    drain = 8'd50;
    cyc(SWEEP);
    expect_val("R5 equal scaled values ignored", duty_of(300 + MARGIN));
    report_val(int'(delay_acc_o));

    // R7 R8: run to the latch
    drain = 8'd51;
    prev_acc = int'(delay_acc_o);
    waited = 0;
    while (!fault_o && waited < 4 * SWEEP) begin
      prev_acc = int'(delay_acc_o);
      @(negedge clk);
      waited++;
    end
    expect_val("R7 fault set", 1);              report_val(int'(fault_o));
    expect_val("R7 acc before trip", QUART - 1); report_val(prev_acc);
    expect_val("R7 acc cleared at trip", 0);    report_val(int'(delay_acc_o));
    expect_val("R8 gate low at trip", 0);       report_val(int'(gate_o));

    bad = 0;
    for (int i = 0; i < 2 * SWEEP; i++) begin
      @(negedge clk);
      if (gate_o || !fault_o || delay_acc_o != '0) bad++;
    end
    expect_val("R8 gate held low with oc", 0);
    report_val(bad);

    // R9: latch holds after the over-current is removed
    drain = 8'd0;
    speed_cmd = TRI_W'(0);
    bad = 0;
    for (int i = 0; i < SWEEP; i++) begin
      @(negedge clk);
      if (gate_o || !fault_o) bad++;
    end
    expect_val("R9 latch sticky", 0);
    report_val(bad);

    // R10: reset clears the latch and re-enables the gate
    speed_cmd = TRI_W'(300);
    apply_reset();
    check_duty("R10 duty after reset", 300);
    expect_val("R10 fault clear after reset", 0);
    report_val(int'(fault_o));

    cyc(4);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule